// File: doc/BRIEF.md
# Sign-Magnitude Successive-Approximation Conversion Controller

This block runs a successive-approximation conversion under instruction control. It owns a 9-bit approximation register: one sign bit and eight magnitude bits. The register drives an external converter, and the block reads back one comparator bit. Software issues one instruction strobe per slot. A start slot clears the register. After it, each convert slot resolves one bit, sign first and then the magnitude bits from the most significant down. A convert slot must be followed by two idle slots before the next convert is accepted. The result stays in the register until it is replaced.

The same register feeds the analog output path. A load instruction writes a value into it. A chop instruction inverts every bit, so that alternating output strobes can send a value and its ones' complement on one channel. An output instruction produces a one-cycle strobe carrying the register value. The strobe is produced only after the converter has had enough idle slots to settle since the register last changed.

Top module: `sarConvCtl`

## Requirements
- R1: The reset input is synchronous and active high. Reset clears the approximation register, the done flag and the output strobe. It returns the bit index to the sign step, so the first convert after reset is accepted at once.
- R2: An instruction slot is a cycle with `instValid` high. `instOp` encodes 0 idle, 1 start, 2 convert, 3 load, 4 output and 5 chop; codes 6 and 7 do nothing. A convert presented while `instValid` is low has no effect.
- R3: A start slot clears the register and the done flag. It restarts the conversion at the sign step, and that step may then be accepted at once.
- R4: The first accepted convert writes the comparator bit into bit 8, the sign (1 = negative). In the same step it sets bit 7 tentatively.
- R5: Each later accepted convert works on the current tentative magnitude bit, from bit 7 down to bit 0. It keeps that bit when the comparator bit is 1 and clears it when the bit is 0. It then sets the next lower bit tentatively. The ninth accepted convert raises done.
- R6: A convert is accepted only once at least 2 idle slots have passed since the previous accepted convert. An earlier convert leaves the register and the bit index unchanged.
- R7: A convert that arrives while done is high is ignored. Done stays high until a start slot or a reset.
- R8: A load slot writes `loadData` into the register.
- R9: A chop slot replaces the register with its bitwise inverse.
- R10: An output slot raises `outStrobe` for one cycle in the next cycle, with `outData` equal to the register value. This happens only when at least 7 idle slots have passed since the last start, accepted convert, load or chop; otherwise the slot produces no strobe. Output slots do not restart this count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Marks an instruction slot |
| instOp | input | 3 | Instruction code |
| loadData | input | 9 | Value written by a load slot |
| cmpIn | input | 1 | Comparator result from the analog path |
| approxReg | output | 9 | Approximation register, sign in bit 8 |
| outStrobe | output | 1 | Output strobe for the analog output channel |
| outData | output | 9 | Value carried with the output strobe |
| done | output | 1 | All nine bits resolved |

## Verification
The assertions take for granted that only one instruction is presented per cycle. They also assume that `cmpIn` and `loadData` are valid and stable in the cycle that consumes them. The bench drives every input shortly after a rising edge. It models an ideal comparator that reads the `approxReg` port: during the sign step it reports whether the signed input is negative, and on later steps whether the input magnitude is at least the register's magnitude. Because of this model, every comparator value fed to the block is consistent with a real analog input.

// File: rtl/sarPkg.sv
package sarPkg;
  localparam int MAG_W = 8;
  localparam int RES_W = MAG_W + 1;
  localparam int IDX_W = $clog2(MAG_W + 2);

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_START = 3'd1,
    OP_CVT   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_OUT   = 3'd4,
    OP_CHOP  = 3'd5
  } opT;

  typedef struct packed {
    logic             clr;
    logic             load;
    logic             inv;
    logic             step;
    logic [IDX_W-1:0] stepIdx;
    logic             emit;
  } ctrlT;
endpackage

// File: rtl/sarCtrl.sv
module sarCtrl
  import sarPkg::*;
#(
  parameter int PACE_SLOTS   = 2,
  parameter int SETTLE_SLOTS = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       instValid,
  input  logic [2:0] instOp,
  output ctrlT       ctrl,
  output logic       done
);
  localparam int PW = $clog2(PACE_SLOTS + 1);
  localparam int SW = $clog2(SETTLE_SLOTS + 1);
  localparam logic [PW-1:0] PACE_MAX = PW'(PACE_SLOTS);
  localparam logic [SW-1:0] SETTLE_MAX = SW'(SETTLE_SLOTS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAG_W);

  logic [IDX_W-1:0] bitIdx;
  logic [PW-1:0]    paceCnt;
  logic [SW-1:0]    settleCnt;
  logic             doneQ;
  opT               op;
  logic             isNop, isStart, isCvt, isLoad, isOut, isChop;
  logic             cvtOk, regChange;

  assign op      = opT'(instOp);
  assign isNop   = instValid && (op == OP_NOP);
  assign isStart = instValid && (op == OP_START);
  assign isCvt   = instValid && (op == OP_CVT);
  assign isLoad  = instValid && (op == OP_LOAD);
  assign isOut   = instValid && (op == OP_OUT);
  assign isChop  = instValid && (op == OP_CHOP);

  assign cvtOk     = isCvt && !doneQ && (paceCnt == PACE_MAX);
  assign regChange = isStart || cvtOk || isLoad || isChop;

  always_comb begin
    ctrl.clr     = isStart;
    ctrl.load    = isLoad;
    ctrl.inv     = isChop;
    ctrl.step    = cvtOk;
    ctrl.stepIdx = bitIdx;
    ctrl.emit    = isOut && (settleCnt == SETTLE_MAX);
  end

  assign done = doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitIdx  <= '0;
      doneQ   <= 1'b0;
      paceCnt <= PACE_MAX;
    end else if (isStart) begin
      bitIdx  <= '0;
      doneQ   <= 1'b0;
      paceCnt <= PACE_MAX;
    end else if (cvtOk) begin
      bitIdx  <= bitIdx + 1'b1;
      paceCnt <= '0;
      if (bitIdx == LAST_IDX) doneQ <= 1'b1;
    end else if (isNop && paceCnt != PACE_MAX) begin
      paceCnt <= paceCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || regChange) begin
      settleCnt <= '0;
    end else if (isNop && settleCnt != SETTLE_MAX) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrlT             ctrl,
  input  logic             cmpIn,
  input  logic [RES_W-1:0] loadData,
  output logic [RES_W-1:0] approxReg,
  output logic             outStrobe,
  output logic [RES_W-1:0] outData
);
  logic [RES_W-1:0] regQ;
  logic [RES_W-1:0] regNext;

  always_comb begin
    regNext = regQ;
    if (ctrl.clr) begin
      regNext = '0;
    end else if (ctrl.load) begin
      regNext = loadData;
    end else if (ctrl.inv) begin
      regNext = ~regQ;
    end else if (ctrl.step) begin
      for (int b = 0; b < RES_W; b++) begin
        if (b == MAG_W - int'(ctrl.stepIdx)) regNext[b] = cmpIn;
        if (b < MAG_W && b == MAG_W - 1 - int'(ctrl.stepIdx)) regNext[b] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regQ      <= '0;
      outStrobe <= 1'b0;
      outData   <= '0;
    end else begin
      regQ      <= regNext;
      outStrobe <= ctrl.emit;
      if (ctrl.emit) outData <= regQ;
    end
  end

  assign approxReg = regQ;
endmodule

// File: rtl/sarConvCtl.sv
module sarConvCtl
  import sarPkg::*;
#(
  parameter int PACE_SLOTS   = 2,
  parameter int SETTLE_SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic [2:0]       instOp,
  input  logic [RES_W-1:0] loadData,
  input  logic             cmpIn,
  output logic [RES_W-1:0] approxReg,
  output logic             outStrobe,
  output logic [RES_W-1:0] outData,
  output logic             done
);
  ctrlT ctrl;

  sarCtrl #(
    .PACE_SLOTS  (PACE_SLOTS),
    .SETTLE_SLOTS(SETTLE_SLOTS)
  ) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .instValid(instValid),
    .instOp   (instOp),
    .ctrl     (ctrl),
    .done     (done)
  );

  sarDatapath uDp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .cmpIn    (cmpIn),
    .loadData (loadData),
    .approxReg(approxReg),
    .outStrobe(outStrobe),
    .outData  (outData)
  );
endmodule

// File: rtl/sarConvCtl_chk.sv
module sarConvCtl_chk
  import sarPkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             instValid,
  input logic [2:0]       instOp,
  input logic [RES_W-1:0] loadData,
  input logic [RES_W-1:0] approxReg,
  input logic             outStrobe,
  input logic [RES_W-1:0] outData,
  input logic             done
);
  assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (instValid && instOp == 3'd1) |=> (approxReg == '0 && !done));

  assert_cvt_after_done_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (done && instValid && instOp == 3'd2) |=> ($stable(approxReg) && done));

  assert_done_falls_on_start_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> ($past(rst) || $past(instValid && instOp == 3'd1)));

  assert_load_writes_R8: assert property (@(posedge clk) disable iff (rst)
    (instValid && instOp == 3'd3) |=> (approxReg == $past(loadData)));

  assert_chop_inverts_R9: assert property (@(posedge clk) disable iff (rst)
    (instValid && instOp == 3'd5) |=> (approxReg == ~$past(approxReg)));

  assert_strobe_needs_out_R10: assert property (@(posedge clk) disable iff (rst)
    outStrobe |-> ($past(instValid && instOp == 3'd4) && outData == $past(approxReg)));
endmodule

bind sarConvCtl sarConvCtl_chk uChk (
  .clk      (clk),
  .rst      (rst),
  .instValid(instValid),
  .instOp   (instOp),
  .loadData (loadData),
  .approxReg(approxReg),
  .outStrobe(outStrobe),
  .outData  (outData),
  .done     (done)
);

// File: tb/sarConvCtl_test.sv
module sarConvCtl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  localparam int VEC_IN [NVEC] = '{0, 100, -255, -1, 255, 128, -77};
  localparam logic [8:0] VEC_EXP [NVEC] =
    '{9'h000, 9'h064, 9'h1FF, 9'h101, 9'h0FF, 9'h080, 9'h14D};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       instValid = 1'b0;
  logic [2:0] instOp = 3'd0;
  logic [8:0] loadData = '0;
  logic       cmpIn = 1'b0;
  logic [8:0] approxReg;
  logic       outStrobe;
  logic [8:0] outData;
  logic       done;

  int checks = 0;
  int fails = 0;
  int vIn = 0;
  int stepNo = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sarConvCtl uut (
    .clk(clk), .rst(rst), .instValid(instValid), .instOp(instOp),
    .loadData(loadData), .cmpIn(cmpIn), .approxReg(approxReg),
    .outStrobe(outStrobe), .outData(outData), .done(done)
  );

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one instruction slot; the comparator models an ideal analog compare
  task automatic slot(input logic [2:0] op, input logic [8:0] data = '0);
    int mag;
    mag = (vIn < 0) ? -vIn : vIn;
    instValid = 1'b1;
    instOp    = op;
    loadData  = data;
    if (stepNo == 0) cmpIn = (vIn < 0);
    else             cmpIn = (mag >= int'(approxReg[7:0]));
    @(posedge clk);
    #1;
    if (op == 3'd2) stepNo++;
    instValid = 1'b0;
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) slot(3'd0);
  endtask

  task automatic convert(int value);
    vIn = value;
    stepNo = 0;
    slot(3'd1);
    for (int k = 0; k < 9; k++) begin
      slot(3'd2);
      nops(2);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #1;
    doReset();
    // R1 reset state
    check("R1 reg", approxReg, 9'h000);
    check("R1 done", {8'h0, done}, 9'h000);
    check("R1 strobe", {8'h0, outStrobe}, 9'h000);

    // table of conversions (R4, R5, R7, R10)
    for (int v = 0; v < NVEC; v++) begin
      convert(VEC_IN[v]);
      check("R5 result", approxReg, VEC_EXP[v]);
      check("R5 done", {8'h0, done}, 9'h001);
      nops(7);
      slot(3'd4);
      check("R10 strobe", {8'h0, outStrobe}, 9'h001);
      check("R10 data", outData, VEC_EXP[v]);
    end

    // R6 pacing: an early convert is ignored
    vIn = -5; stepNo = 0;
    slot(3'd1);
    slot(3'd2);
    check("R4 sign step", approxReg, 9'h180);
    slot(3'd2);
    check("R6 back-to-back convert", approxReg, 9'h180);
    nops(1);
    slot(3'd2);
    check("R6 one idle slot", approxReg, 9'h180);
    nops(1);
    slot(3'd2);
    check("R6 two idle slots", approxReg, 9'h140);

    // R7 convert after done ignored, done held
    convert(100);
    slot(3'd2);
    check("R7 reg held", approxReg, 9'h064);
    check("R7 done held", {8'h0, done}, 9'h001);
    slot(3'd0);
    check("R7 done still held", {8'h0, done}, 9'h001);

    // R3 start clears
    slot(3'd1);
    check("R3 reg", approxReg, 9'h000);
    check("R3 done", {8'h0, done}, 9'h000);

    // R8 load, R9 chop
    slot(3'd3, 9'h0A5);
    check("R8 load", approxReg, 9'h0A5);
    slot(3'd5);
    check("R9 chop", approxReg, 9'h15A);
    slot(3'd5);
    check("R9 chop twice", approxReg, 9'h0A5);

    // R10 settle window
    slot(3'd3, 9'h033);
    nops(3);
    slot(3'd4);
    check("R10 unsettled", {8'h0, outStrobe}, 9'h000);
    nops(4);
    slot(3'd4);
    check("R10 settled strobe", {8'h0, outStrobe}, 9'h001);
    check("R10 settled data", outData, 9'h033);
    slot(3'd4);
    check("R10 repeat strobe", {8'h0, outStrobe}, 9'h001);
    slot(3'd5);
    slot(3'd4);
    check("R10 after chop", {8'h0, outStrobe}, 9'h000);

    // R2 invalid slot and unused code
    instOp = 3'd2; cmpIn = 1'b0;
    @(posedge clk); #1;
    check("R2 invalid convert", approxReg, 9'h1CC);
    slot(3'd7);
    check("R2 unused code", approxReg, 9'h1CC);

    // R1 reset mid-conversion
    vIn = -9; stepNo = 0;
    slot(3'd1);
    slot(3'd2);
    check("R1 pre-reset", approxReg, 9'h180);
    doReset();
    check("R1 mid reset reg", approxReg, 9'h000);
    vIn = 9; stepNo = 0;
    slot(3'd2);
    check("R1 sign after reset", approxReg, 9'h080);

    summary();
  end
endmodule